// File: doc/BRIEF.md
# Regulator Start-Up Ramp Sequencer

This block is the digital start-up controller for one output section of a multiphase buck regulator. When the supply is reported valid and the section is enabled, it raises a 9-bit reference code from zero toward a programmed target. The code moves up one step of 6.25 mV after every fixed number of clock ticks, so the ramp time grows in proportion to the target. When the reference reaches the target, the block raises power-good. The analog loop, the comparators and the reference DAC sit outside the block and exchange plain digital flags with it.

During the ramp the block keeps the low-side switch off. The PWM pin stays in high impedance and the driver stays disabled until the control loop asks for its first PWM pulse. From that pulse on, the pin follows the loop request and the driver is enabled. Overvoltage protection is armed at all times. Undervoltage protection is armed only once the reference has passed the code for 0.5 V. Either protection latches a fault. A latched fault drops power-good and returns the reference to zero. An overvoltage fault also turns the low-side switch on, even if the start-up masking is still in force. A fault is held until enable or supply validity is removed.

Top module: `vr_softstart_seq`

## Requirements
- R1: When `supply_ok` or `enable` is low at a clock edge, after that edge `ref_code` is 0 and `pgood`, `fault`, `pwm_oe`, `pwm_val` and `drv_en` are all 0.
- R2: Count the clock edges from the first edge at which both `supply_ok` and `enable` are high, calling that edge 1. After edge 1+k·STEP_TICKS, `ref_code` equals k, for every k up to the target. It then holds at the target, and it never moves by more than one code per edge.
- R3: `pgood` rises after edge 2+T·STEP_TICKS for a target code T. A target of 0 gives `pgood` after edge 2. `ref_code` equals the target when `pgood` rises.
- R4: While `ref_code` is below 80, the code for 0.5 V at 6.25 mV per step, a high `uv_flag` is ignored: `fault` stays 0 and the ramp continues.
- R5: A high `uv_flag` at an edge where `ref_code` is 80 or more sets `fault` to 1 after that edge, with `ref_code` at 0 and `pgood` at 0.
- R6: A high `ov_flag` at any edge while `supply_ok` and `enable` are high sets `fault` after that edge. This holds before the ramp starts, during the ramp and after it.
- R7: From the start of the ramp until `pwm_req` is first seen high, `pwm_oe` (1 = PWM pin driven, 0 = high impedance) and `drv_en` are 0.
- R8: From the cycle in which `pwm_req` is first high during the ramp or after it, `pwm_oe` and `drv_en` are 1 and `pwm_val` follows `pwm_req` in the same cycle.
- R9: After an overvoltage fault, `pwm_oe`=1, `pwm_val`=0 and `drv_en`=1, even if no PWM pulse has yet been seen. After an undervoltage-only fault, `pwm_oe` and `drv_en` are 0.
- R10: `fault` stays at 1 while `supply_ok` and `enable` stay high. It is cleared only by dropping one of them, after which a new ramp starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above its lockout threshold |
| enable | input | 1 | Section enable |
| target_code | input | 9 | Programmed reference target, 6.25 mV per code |
| pwm_req | input | 1 | PWM level requested by the control loop |
| ov_flag | input | 1 | Overvoltage comparator output |
| uv_flag | input | 1 | Undervoltage comparator output |
| ref_code | output | 9 | Reference code sent to the DAC |
| pwm_oe | output | 1 | PWM pin output enable, 0 = high impedance |
| pwm_val | output | 1 | PWM pin level when driven |
| drv_en | output | 1 | Power-stage driver enable |
| pgood | output | 1 | Power-good |
| fault | output | 1 | Latched protection fault |

## Verification
The assertions assume three things about the inputs. `target_code` holds steady whenever `supply_ok` and `enable` are both high. All inputs are synchronous to `clk`. A rise of `pgood` is compared against the target that was present during the whole ramp. The stimulus meets these assumptions as follows: it changes the target only while `enable` is low, and it changes every input at the falling clock edge. It samples the combinational PWM path a short delay after changing `pwm_req`.

// File: rtl/ss_pkg.sv
// Shared types for the start-up ramp sequencer.
// Assumes: nothing beyond a synthesizable enum encoding.
package ss_pkg;

    typedef enum logic [1:0] {
        SS_IDLE  = 2'd0,
        SS_RAMP  = 2'd1,
        SS_DONE  = 2'd2,
        SS_FAULT = 2'd3
    } ss_state_e;

endpackage

// File: rtl/ss_ramp.sv
// Reference ramp generator: advances a code by one step every STEP_TICKS
// enabled cycles and flags when it has reached the target.
// Assumes: target is stable while step_en can be high; clear has priority.
module ss_ramp #(
    parameter int REF_W      = 9,
    parameter int STEP_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step_en,
    input  logic [REF_W-1:0] target,
    output logic [REF_W-1:0] ref_q,
    output logic             at_target
);
    localparam int CNT_W = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_TICKS - 1);

    logic [CNT_W-1:0] tick_q;

    // Target reached when the code is at or above it.
    assign at_target = (ref_q >= target);

    // Tick divider and reference register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ref_q  <= '0;
            tick_q <= '0;
        end else if (step_en) begin
            if (tick_q == CNT_LAST) begin
                tick_q <= '0;
                ref_q  <= ref_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    // R2: the code moves by at most one step per edge (or is cleared).
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (ref_q == $past(ref_q)) || (ref_q == $past(ref_q) + 1'b1) || (ref_q == '0));

    // R2: stepping never carries the code beyond the target.
    assert_no_overshoot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (ref_q <= target));

endmodule

// File: rtl/ss_protect.sv
// Protection arming: overvoltage always armed, undervoltage armed once the
// reference reaches UV_ARM_CODE; records whether the trip was overvoltage.
// Assumes: faulted reflects the registered fault state of the sequencer.
module ss_protect #(
    parameter int REF_W       = 9,
    parameter int UV_ARM_CODE = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             active,
    input  logic             faulted,
    input  logic [REF_W-1:0] ref_code,
    input  logic             ov_flag,
    input  logic             uv_flag,
    output logic             trip,
    output logic             ov_cause_q
);
    localparam logic [REF_W-1:0] UV_ARM = REF_W'(UV_ARM_CODE);

    logic uv_armed;

    // Undervoltage arming threshold on the present reference.
    assign uv_armed = (ref_code >= UV_ARM);

    // New fault request while running and not yet faulted.
    assign trip = run && !faulted && (ov_flag || (active && uv_armed && uv_flag));

    // Remember an overvoltage cause until the section is switched off.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ov_cause_q <= 1'b0;
        end else if (trip && ov_flag) begin
            ov_cause_q <= 1'b1;
        end
    end

    // R9: an overvoltage cause only exists together with the fault state.
    assert_ov_cause_in_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ov_cause_q |-> faulted);

endmodule

// File: rtl/ss_gate.sv
// Driver gating: holds the PWM pin in high impedance and the driver off
// until the first requested pulse, and applies the overvoltage crowbar.
// Assumes: idle, active and faulted are mutually exclusive state decodes.
module ss_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic active,
    input  logic faulted,
    input  logic ov_cause,
    input  logic pwm_req,
    output logic pwm_oe,
    output logic pwm_val,
    output logic drv_en
);
    logic started_q;

    // First-pulse tracker, rearmed whenever the section returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || idle) begin
            started_q <= 1'b0;
        end else if (active && pwm_req) begin
            started_q <= 1'b1;
        end
    end

    // Output selection: crowbar, normal switching, or masked.
    always_comb begin
        pwm_oe  = 1'b0;
        pwm_val = 1'b0;
        drv_en  = 1'b0;
        if (faulted) begin
            if (ov_cause) begin
                pwm_oe = 1'b1;
                drv_en = 1'b1;
            end
        end else if (active && (started_q || pwm_req)) begin
            pwm_oe  = 1'b1;
            pwm_val = pwm_req;
            drv_en  = 1'b1;
        end
    end

    // R7: outside a fault the pin only leaves high impedance on a pulse.
    assert_first_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwm_oe) && !faulted) |-> pwm_req);

    // R8: a driven pin always comes with an enabled driver.
    assert_oe_with_drv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_oe |-> drv_en);

endmodule

// File: rtl/vr_softstart_seq.sv
// Start-up sequencer for one regulator section: state machine tying the
// reference ramp, protection arming and driver gating together.
// Assumes: inputs synchronous to clk; target_code steady while running.
module vr_softstart_seq #(
    parameter int REF_W       = 9,
    parameter int STEP_TICKS  = 4,
    parameter int UV_ARM_CODE = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             enable,
    input  logic [REF_W-1:0] target_code,
    input  logic             pwm_req,
    input  logic             ov_flag,
    input  logic             uv_flag,
    output logic [REF_W-1:0] ref_code,
    output logic             pwm_oe,
    output logic             pwm_val,
    output logic             drv_en,
    output logic             pgood,
    output logic             fault
);
    import ss_pkg::*;

    ss_state_e st_q, st_d;
    logic run, active, trip, at_target, ov_cause, ramp_clear, step_en;

    assign run    = supply_ok && enable;
    assign active = (st_q == SS_RAMP) || (st_q == SS_DONE);

    // Next-state decision.
    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = SS_IDLE;
        end else begin
            unique case (st_q)
                SS_IDLE:  st_d = trip ? SS_FAULT : SS_RAMP;
                SS_RAMP:  st_d = trip ? SS_FAULT : (at_target ? SS_DONE : SS_RAMP);
                SS_DONE:  st_d = trip ? SS_FAULT : SS_DONE;
                SS_FAULT: st_d = SS_FAULT;
                default:  st_d = SS_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SS_IDLE;
        else        st_q <= st_d;
    end

    assign ramp_clear = (st_d == SS_IDLE) || (st_d == SS_FAULT);
    assign step_en    = (st_q == SS_RAMP) && !at_target;

    ss_ramp #(.REF_W(REF_W), .STEP_TICKS(STEP_TICKS)) u_ramp (
        .clk(clk), .rst_n(rst_n), .clear(ramp_clear), .step_en(step_en),
        .target(target_code), .ref_q(ref_code), .at_target(at_target)
    );

    ss_protect #(.REF_W(REF_W), .UV_ARM_CODE(UV_ARM_CODE)) u_protect (
        .clk(clk), .rst_n(rst_n), .run(run), .active(active),
        .faulted(st_q == SS_FAULT), .ref_code(ref_code),
        .ov_flag(ov_flag), .uv_flag(uv_flag), .trip(trip), .ov_cause_q(ov_cause)
    );

    ss_gate u_gate (
        .clk(clk), .rst_n(rst_n), .idle(st_q == SS_IDLE), .active(active),
        .faulted(st_q == SS_FAULT), .ov_cause(ov_cause), .pwm_req(pwm_req),
        .pwm_oe(pwm_oe), .pwm_val(pwm_val), .drv_en(drv_en)
    );

    assign pgood = (st_q == SS_DONE);
    assign fault = (st_q == SS_FAULT);

    // R1: dropping supply or enable leaves everything quiet on the next cycle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (ref_code == '0) && !pgood && !fault && !pwm_oe && !drv_en);

    // R3: power-good only appears with the reference at the target.
    assert_pgood_at_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> (ref_code == target_code));

    // R4: undervoltage below the arming code never creates a fault.
    assert_uv_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !ov_flag && (ref_code < REF_W'(UV_ARM_CODE))) |=> !fault);

    // R5: a fault holds the reference at zero and power-good low.
    assert_fault_zero_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (ref_code == '0) && !pgood);

    // R6: overvoltage while running always ends in the fault state.
    assert_ov_trips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ov_flag) |=> fault);

    // R10: a fault persists while the section stays enabled and supplied.
    assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && run) |=> fault);

endmodule

// File: tb/vr_softstart_seq_bench.sv
module vr_softstart_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STEP = 4;
    localparam int UVC  = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0, enable = 1'b0, pwm_req = 1'b0;
    logic       ov_flag = 1'b0, uv_flag = 1'b0;
    logic [8:0] target_code = '0;
    logic [8:0] ref_code;
    logic       pwm_oe, pwm_val, drv_en, pgood, fault;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vr_softstart_seq #(.REF_W(9), .STEP_TICKS(STEP), .UV_ARM_CODE(UVC)) u_vr_softstart_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
        .target_code(target_code), .pwm_req(pwm_req), .ov_flag(ov_flag),
        .uv_flag(uv_flag), .ref_code(ref_code), .pwm_oe(pwm_oe), .pwm_val(pwm_val),
        .drv_en(drv_en), .pgood(pgood), .fault(fault)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic chk_quiet(input string what);
        chk({what, " ref"}, ref_code, 0);
        chk({what, " pgood"}, pgood, 0);
        chk({what, " fault"}, fault, 0);
        chk({what, " pwm_oe"}, pwm_oe, 0);
        chk({what, " drv_en"}, drv_en, 0);
    endtask

    task automatic go_idle();
        enable = 1'b0; pwm_req = 1'b0; ov_flag = 1'b0; uv_flag = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    // R1: reset and lockout keep the section idle.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_quiet("R1 after reset");
        enable = 1'b1; target_code = 9'd20;
        repeat (6) @(negedge clk);
        chk_quiet("R1 enable without supply");
        enable = 1'b0; supply_ok = 1'b1;
        repeat (3) @(negedge clk);
        chk_quiet("R1 supply without enable");
    endtask

    // R2, R3, R7, R8: full ramp to a target, then first pulse behaviour.
    task automatic t_ramp(input int tgt);
        int bad_ref, bad_gate, pg_edge, exp_ref;
        bad_ref = 0; bad_gate = 0; pg_edge = -1;
        go_idle();
        target_code = 9'(tgt);
        enable = 1'b1;
        for (int e = 1; e <= tgt * STEP + 4; e++) begin
            @(negedge clk);
            exp_ref = (e - 1) / STEP;
            if (exp_ref > tgt) exp_ref = tgt;
            if (ref_code != 9'(exp_ref)) bad_ref++;
            if (pgood && pg_edge < 0) pg_edge = e;
            if (pwm_oe || drv_en) bad_gate++;
        end
        chk("R2 ramp code mismatches", bad_ref, 0);
        chk("R3 pgood rise edge", pg_edge, 2 + tgt * STEP);
        chk("R3 final ref", ref_code, tgt);
        chk("R7 masked cycles with driver active", bad_gate, 0);
        pwm_req = 1'b1; #1;
        chk("R8 first pulse pwm_oe", pwm_oe, 1);
        chk("R8 first pulse pwm_val", pwm_val, 1);
        chk("R8 first pulse drv_en", drv_en, 1);
        @(negedge clk);
        pwm_req = 1'b0; #1;
        chk("R8 low phase pwm_oe", pwm_oe, 1);
        chk("R8 low phase pwm_val", pwm_val, 0);
        chk("R8 low phase drv_en", drv_en, 1);
        enable = 1'b0;
        @(negedge clk);
        chk_quiet("R1 after disable");
    endtask

    // R4, R5, R9, R10: undervoltage masked then armed.
    task automatic t_uv();
        int code_before;
        go_idle();
        target_code = 9'd120;
        enable = 1'b1;
        while (ref_code < 9'd40) @(negedge clk);
        code_before = ref_code;
        uv_flag = 1'b1;
        repeat (2 * STEP) @(negedge clk);
        uv_flag = 1'b0;
        chk("R4 uv below arming fault", fault, 0);
        chk("R4 ramp continued", ref_code, code_before + 2);
        while (ref_code < 9'(UVC)) @(negedge clk);
        uv_flag = 1'b1;
        @(negedge clk);
        uv_flag = 1'b0;
        chk("R5 uv armed fault", fault, 1);
        chk("R5 ref cleared", ref_code, 0);
        chk("R5 pgood low", pgood, 0);
        chk("R9 uv fault pwm_oe", pwm_oe, 0);
        chk("R9 uv fault drv_en", drv_en, 0);
        repeat (5) @(negedge clk);
        chk("R10 fault held", fault, 1);
        chk("R10 ref held at zero", ref_code, 0);
        enable = 1'b0;
        @(negedge clk);
        chk_quiet("R10 fault cleared by disable");
    endtask

    // R6, R9: overvoltage during ramp and before ramp.
    task automatic t_ov();
        go_idle();
        target_code = 9'd60;
        enable = 1'b1;
        repeat (7) @(negedge clk);
        ov_flag = 1'b1;
        @(negedge clk);
        ov_flag = 1'b0;
        chk("R6 ov during ramp fault", fault, 1);
        chk("R9 ov crowbar pwm_oe", pwm_oe, 1);
        chk("R9 ov crowbar pwm_val", pwm_val, 0);
        chk("R9 ov crowbar drv_en", drv_en, 1);
        chk("R6 ov pgood low", pgood, 0);
        repeat (3) @(negedge clk);
        chk("R10 ov fault held", fault, 1);
        go_idle();
        chk_quiet("R10 ov fault cleared");
        enable = 1'b1; ov_flag = 1'b1;
        @(negedge clk);
        ov_flag = 1'b0;
        chk("R6 ov before ramp fault", fault, 1);
        chk("R6 ov before ramp ref", ref_code, 0);
        go_idle();
    endtask

    // R1, R10: supply loss mid-ramp, then a fresh ramp from zero.
    task automatic t_supply_drop();
        go_idle();
        target_code = 9'd50;
        enable = 1'b1;
        repeat (30) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        chk_quiet("R1 supply lost mid-ramp");
        supply_ok = 1'b1;
        @(negedge clk);
        chk("R10 restart ref zero", ref_code, 0);
        repeat (STEP) @(negedge clk);
        chk("R10 restart first step", ref_code, 1);
        go_idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_ramp(10);
        t_ramp(0);
        t_ramp(1);
        t_uv();
        t_ov();
        t_supply_drop();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule